// File: doc/BRIEF.md
# Breathing LED PWM generator

The block drives a single pulse-width-modulated line whose duty cycle climbs and falls slowly and linearly between a programmable floor and ceiling, so that an attached LED appears to breathe. Each PWM period lasts a programmable number of counted ticks. The duty stays the same for a programmable number of whole periods, then moves by one count toward the current end of its range. It turns around at the ceiling and again at the floor, and the pattern repeats for as long as the block is enabled.

A `tick` input paces all counting, normally a strobe derived from a fast clock. A `pause` input lets a neighbouring PWM controller freeze the whole pattern in place. Settings are written through a narrow write port. Range and timing settings are staged and applied only at a period boundary, so that a write never leaves a cut-short or stretched pulse. Enable and polarity act at once.

Top module: `breath_pwm`

## Requirements
- R1: After reset the settings are: period field 255, hold field 1, ceiling 10, floor 1, breathing disabled, polarity 0. The output is therefore low.
- R2: A write with `wr_en` high stores `wr_data` into the setting chosen by `wr_addr`. The addresses are 0 = period field, 1 = hold field, 2 = ceiling, 3 = floor, 4 = control. In the control setting, bit 0 is enable and bit 1 is polarity.
- R3: While enabled, a PWM period spans period field + 1 counted edges. A counted edge is a clock edge with `tick` high and `pause` low. The line is active while the position inside the period is below the current duty.
- R4: The duty stays unchanged for hold field + 1 consecutive periods before it moves.
- R5: The first period after enabling uses the floor as its duty. The duty then rises by one per step to the ceiling and falls by one per step back to the floor. It repeats this triangle with no extra dwell at either end.
- R6: If the ceiling equals the floor, the duty is constant. A duty above the period field keeps the line active for the whole period. A duty of 0 keeps the line idle.
- R7: Polarity 0 makes the idle level low and the active level high. Polarity 1 inverts both levels.
- R8: While enable is 0, the line sits at the idle level, and the period counter, hold counter and duty are cleared back to their start values. Enabling again restarts from the beginning of the pattern.
- R9: While `pause` is high, the period counter, hold counter and duty ramp all stay frozen.
- R10: A clock edge with `tick` low does not advance the pattern.
- R11: A new period field, hold field, ceiling or floor takes effect only at the next period boundary. The period that is running when the write arrives finishes with its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable strobe from the fast clock divider |
| pause | input | 1 | Freeze request from an external PWM controller |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 3 | Setting select (0 period, 1 hold, 2 ceiling, 3 floor, 4 control) |
| wr_data | input | CW (8) | Setting write value |
| pwm_out | output | 1 | Breathing PWM line |

## Verification
Runs with the reset settings and no gaps in the tick stream check the basic duty staircase and the double period hold. Randomized rounds use short periods, short holds, random ranges (including an equal floor and ceiling, and a duty above the period) and both polarities, with `tick` gaps and `pause` bursts mixed in. These rounds separate correct counted-edge accounting from designs that count raw clocks or keep running while paused. A directed case rewrites the period field in the middle of a period, which tells a deferred update apart from an immediate one. Another directed case disables and then re-enables the block, which shows that the idle level holds and that the pattern restarts from the floor.

// File: rtl/breath_pwm.sv
module breath_pwm #(
  parameter int              CW       = 8,
  parameter logic [CW-1:0]   DIV_RST  = 8'd255,
  parameter logic [CW-1:0]   STEP_RST = 8'd1,
  parameter logic [CW-1:0]   MAX_RST  = 8'd10,
  parameter logic [CW-1:0]   MIN_RST  = 8'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pause,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out
);
  localparam logic [2:0] A_DIV = 3'd0, A_STEP = 3'd1, A_MAX = 3'd2, A_MIN = 3'd3, A_CTRL = 3'd4;

  logic [CW-1:0] cfg_div, cfg_step, cfg_max, cfg_min;
  logic          cfg_en, cfg_pol;
  logic [CW-1:0] act_div, act_step, act_max, act_min;
  logic [CW-1:0] pcnt, scnt, duty, duty_nx;
  logic          up, up_nx;

  wire run      = cfg_en & tick & ~pause;
  wire per_end  = (pcnt == act_div);
  wire hold_end = (scnt == act_step);

  always_comb begin
    duty_nx = duty;
    up_nx   = up;
    if (up) begin
      if (duty < act_max) begin
        duty_nx = duty + 1'b1;
        if (duty_nx >= act_max) up_nx = 1'b0;
      end else begin
        up_nx = 1'b0;
        if (duty > act_min) duty_nx = duty - 1'b1;
      end
    end else begin
      if (duty > act_min) begin
        duty_nx = duty - 1'b1;
        if (duty_nx <= act_min) up_nx = 1'b1;
      end else begin
        up_nx = 1'b1;
        if (duty < act_max) duty_nx = duty + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_div  <= DIV_RST;
      cfg_step <= STEP_RST;
      cfg_max  <= MAX_RST;
      cfg_min  <= MIN_RST;
      cfg_en   <= 1'b0;
      cfg_pol  <= 1'b0;
      act_div  <= DIV_RST;
      act_step <= STEP_RST;
      act_max  <= MAX_RST;
      act_min  <= MIN_RST;
      pcnt     <= '0;
      scnt     <= '0;
      duty     <= MIN_RST;
      up       <= 1'b1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_DIV:   cfg_div  <= wr_data;
          A_STEP:  cfg_step <= wr_data;
          A_MAX:   cfg_max  <= wr_data;
          A_MIN:   cfg_min  <= wr_data;
          A_CTRL:  begin cfg_en <= wr_data[0]; cfg_pol <= wr_data[1]; end
          default: ;
        endcase
      end
      if (!cfg_en) begin
        pcnt     <= '0;
        scnt     <= '0;
        duty     <= cfg_min;
        up       <= 1'b1;
        act_div  <= cfg_div;
        act_step <= cfg_step;
        act_max  <= cfg_max;
        act_min  <= cfg_min;
      end else if (run) begin
        if (per_end) begin
          pcnt     <= '0;
          act_div  <= cfg_div;
          act_step <= cfg_step;
          act_max  <= cfg_max;
          act_min  <= cfg_min;
          if (hold_end) begin
            scnt <= '0;
            duty <= duty_nx;
            up   <= up_nx;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  assign pwm_out = cfg_en ? ((pcnt < duty) ^ cfg_pol) : cfg_pol;
endmodule

// File: rtl/breath_pwm_chk.sv
module breath_pwm_chk #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pause,
  input logic          cfg_en,
  input logic [CW-1:0] cfg_min,
  input logic [CW-1:0] act_div,
  input logic [CW-1:0] pcnt,
  input logic [CW-1:0] scnt,
  input logic [CW-1:0] duty
);
  assert_pause_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && pause) |=> ($stable(pcnt) && $stable(scnt) && $stable(duty)));

  assert_pos_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (pcnt <= act_div));

  assert_duty_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (duty == $past(duty) || duty == $past(duty) + 1'b1 || duty + 1'b1 == $past(duty)));

  assert_stage_at_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !(tick && !pause && pcnt == act_div)) |=> $stable(act_div));

  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (pcnt == '0 && scnt == '0 && duty == $past(cfg_min)));
endmodule

bind breath_pwm breath_pwm_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pause(pause), .cfg_en(cfg_en),
  .cfg_min(cfg_min), .act_div(act_div), .pcnt(pcnt), .scnt(scnt), .duty(duty)
);

// File: tb/tb_breath_pwm.sv
module tb_breath_pwm;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pause = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int checks = 0, failures = 0;
  int b_div, b_step, b_min, b_max, b_pol, n;
  bit done = 0;

  always #10 clk = ~clk;

  breath_pwm dut (.clk(clk), .rst_n(rst_n), .tick(tick), .pause(pause), .wr_en(wr_en),
                  .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out));

  function automatic int tri_duty(int s, int mn, int mx);
    int l, p;
    l = mx - mn;
    if (l <= 0) return mn;
    p = s % (2 * l);
    return (p <= l) ? mn + p : mn + 2 * l - p;
  endfunction

  function automatic bit exp_out(int cnt);
    int pos, per, d;
    pos = cnt % (b_div + 1);
    per = cnt / (b_div + 1);
    d   = tri_duty(per / (b_step + 1), b_min, b_max);
    return bit'((pos < d) ? 1 : 0) ^ bit'(b_pol);
  endfunction

  task automatic check(input bit exp, input string req);
    checks++;
    if (pwm_out !== exp) begin
      failures++;
      $display("FAIL %s n=%0d actual=%b expected=%b", req, n, pwm_out, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d); tick = 1'b0; pause = 1'b0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cyc(input bit tk, input bit ps, input string req);
    check(exp_out(n), req);
    tick = tk; pause = ps;
    @(posedge clk);
    if (tk && !ps) n++;
    @(negedge clk);
  endtask

  task automatic start(input int dv, input int st, input int mn, input int mx, input int pl);
    wr(4, 0);
    wr(0, dv); wr(1, st); wr(2, mx); wr(3, mn);
    b_div = dv; b_step = st; b_min = mn; b_max = mx; b_pol = pl;
    wr(4, (pl << 1) | 1);
    n = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state is disabled with polarity 0, so the line idles low
    n = 0; b_div = 255; b_step = 1; b_min = 1; b_max = 10; b_pol = 0;
    check(1'b0, "R1 reset idle");
    // R1 R2: enable via control bit 0 with reset settings untouched
    wr(4, 1);
    n = 0;
    for (int i = 0; i < 2100; i++) cyc(1'b1, 1'b0, "R1/R3/R4 default pattern");

    // R6: ceiling equals floor and exceeds the period field -> always active
    start(3, 0, 5, 5, 0);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, "R6 duty above period");
    // R6: duty 0 -> never active, polarity 1 shows idle high (R7)
    start(4, 1, 0, 0, 1);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, "R6/R7 zero duty");

    // R3 R4 R5 R7 R9 R10: randomized settings with tick gaps and pause bursts
    for (int r = 0; r < 12; r++) begin
      int dv, st, mn, mx, len;
      dv = $urandom_range(0, 7);
      st = $urandom_range(0, 3);
      mn = $urandom_range(0, dv + 2);
      mx = mn + $urandom_range(0, 4);
      start(dv, st, mn, mx, $urandom_range(0, 1));
      len = (dv + 1) * (st + 1) * (2 * (mx - mn) + 2) * 2 + 20;
      if (len > 1500) len = 1500;
      for (int i = 0; i < len; i++)
        cyc($urandom_range(0, 3) != 0, $urandom_range(0, 6) == 0, "R3/R4/R5/R7/R9/R10 random");
    end

    // R9: long pause with ticks running holds the line
    start(5, 0, 1, 4, 0);
    for (int i = 0; i < 9; i++) cyc(1'b1, 1'b0, "R9 pre-pause");
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b1, "R9 paused");
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, "R9 resumed");
    // R10: ticks absent, pattern does not advance
    for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, "R10 no tick");

    // R8: disable with polarity 1 -> idle high while ticks run, then restart
    wr(4, 2);
    for (int i = 0; i < 20; i++) begin
      tick = 1'b1;
      checks++;
      if (pwm_out !== 1'b1) begin
        failures++;
        $display("FAIL R8 disabled actual=%b expected=1", pwm_out);
      end
      @(negedge clk);
    end
    b_pol = 1;
    wr(4, 3);
    n = 0;
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'b0, "R8 restart from floor");

    // R11: period field rewritten mid-period; current period keeps old length
    start(3, 0, 2, 2, 0);
    cyc(1'b1, 1'b0, "R11 lead-in");
    check(1'b1, "R11 lead-in pos1");
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd7; tick = 1'b1; pause = 1'b0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    begin
      bit [10:0] seq;
      seq = 11'b0_0_1_1_0_0_0_0_0_0_1;
      for (int i = 10; i >= 0; i--) begin
        checks++;
        if (pwm_out !== seq[i]) begin
          failures++;
          $display("FAIL R11 step=%0d actual=%b expected=%b", 10 - i, pwm_out, seq[i]);
        end
        @(negedge clk);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule